// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital sequencer of a dual-slope current-measuring converter. A single-cycle start request begins a conversion. The sequencer first closes the input switch for a fixed window of 2^CNT_W fast-clock cycles, and the integrator accumulates the sensor current during that window. It then opens every switch for one cycle. After that it closes the reference switch, which connects a reference current of the opposite sign, and counts fast-clock cycles until a comparator reports that the integrator has returned to zero.

The comparator bit is asynchronous to the clock, so it passes through a two-flop synchroniser before the sequencer reads it. The count Z is reported together with a one-cycle valid strobe. The input current is then Z/2^CNT_W times the reference current, with the opposite sign. If the comparator never trips, the discharge count saturates. In that case the result reads full scale, 2^CNT_W, and an overflow flag is raised. After each conversion the sequencer returns to idle with both switches open.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, en_input, en_ref, busy, valid and overflow are all 0 and result is 0.
- R2: A start pulse sampled at a clock edge while idle makes en_input and busy 1 in the cycle that follows that edge.
- R3: en_input stays high for exactly 2^CNT_W consecutive cycles per conversion.
- R4: en_input and en_ref are never 1 in the same cycle. Between the last en_input cycle and the first en_ref cycle there is exactly one cycle in which both are 0.
- R5: The comparator input may first be driven to 1 in the cycle numbered j of the discharge, where j=0 is the first cycle with en_ref high. If j+2 is at most 2^CNT_W-1, the result is j+2 with overflow 0, and en_ref stays high for j+3 cycles, because the comparator passes through two synchroniser flops.
- R6: If the synchronised comparator bit has not tripped by the time the count would reach 2^CNT_W, the result is 2^CNT_W, overflow is 1, and en_ref was high for exactly 2^CNT_W cycles.
- R7: valid is a single-cycle pulse. It appears in the first cycle after en_ref falls, and in that cycle busy, en_input and en_ref are all 0.
- R8: A start pulse that arrives while busy is 1 is ignored: no new integration window begins after the conversion ends.
- R9: result and overflow hold their values from one valid pulse to the next. Overflow returns to 0 on a conversion that ends with a comparator trip.
- R10: If the comparator is already 1 when the discharge begins, the result is 0 with overflow 0, and en_ref is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle conversion request |
| zero_cmp | input | 1 | Asynchronous comparator bit, 1 when the integrator is back at zero |
| en_input | output | 1 | Closes the sensor-current switch |
| en_ref | output | 1 | Closes the opposite-sign reference switch |
| result | output | CNT_W+1 | Discharge cycle count Z |
| overflow | output | 1 | Result saturated at full scale |
| valid | output | 1 | One-cycle strobe: result and overflow are fresh |
| busy | output | 1 | A conversion is in progress |

## Verification
A fault in the phase register or in the window comparison shows up directly at the switch enables. The integration window would be the wrong length, the break-before-make cycle would be missing, or both enables would be high together, and each of these is visible within one conversion. A shared counter that is not cleared between phases, or a synchroniser with the wrong depth, shifts the result by a fixed amount. Such a shift is caught on the first conversion that trips. A wrong saturation limit is exposed on the first conversion in which the comparator never trips.

// File: rtl/dss_pkg.sv
package dss_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_INTEG = 2'd1,
      PH_GAP   = 2'd2,
      PH_DISCH = 2'd3
   } dss_phase_e;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dss_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dss_counter.sv
module dss_counter #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   if (W < 2) begin : g_bad_w
      $error("dss_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;

   // R3 and R6: the sequencer stops counting before the counter would wrap
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |-> (cnt != '1));
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
   import dss_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             zero_s,
   input  logic [CNT_W-1:0] cnt,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output logic             en_input,
   output logic             en_ref,
   output logic             busy,
   output logic             valid,
   output logic [CNT_W:0]   result,
   output logic             overflow
);
   localparam logic [CNT_W-1:0] LAST  = {CNT_W{1'b1}};
   localparam logic [CNT_W:0]   FULL  = {1'b1, {CNT_W{1'b0}}};

   dss_phase_e ph, ph_n;
   logic       fin, fin_ovf;

   always_comb begin
      ph_n    = ph;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      fin     = 1'b0;
      fin_ovf = 1'b0;
      unique case (ph)
         PH_IDLE: if (start) begin
            ph_n    = PH_INTEG;
            cnt_clr = 1'b1;
         end
         PH_INTEG: if (cnt == LAST) begin
            ph_n    = PH_GAP;
            cnt_clr = 1'b1;
         end else begin
            cnt_inc = 1'b1;
         end
         PH_GAP: ph_n = PH_DISCH;
         PH_DISCH: if (zero_s) begin
            fin  = 1'b1;
            ph_n = PH_IDLE;
         end else if (cnt == LAST) begin
            fin     = 1'b1;
            fin_ovf = 1'b1;
            ph_n    = PH_IDLE;
         end else begin
            cnt_inc = 1'b1;
         end
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ph       <= PH_IDLE;
         valid    <= 1'b0;
         result   <= '0;
         overflow <= 1'b0;
      end else begin
         ph    <= ph_n;
         valid <= fin;
         if (fin) begin
            result   <= fin_ovf ? FULL : {1'b0, cnt};
            overflow <= fin_ovf;
         end
      end

   assign en_input = (ph == PH_INTEG);
   assign en_ref   = (ph == PH_DISCH);
   assign busy     = (ph != PH_IDLE);

   // R4: switches exclusive, and one dead cycle before the reference closes
   a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_input && en_ref));
   a_r4_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_input) |-> !en_ref);
   a_r4_ref_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_ref) |-> $past(!en_input));
   // R7: single-cycle strobe while idle
   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (!busy && !en_input && !en_ref));
   // R6: saturated result is full scale
   a_r6_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && overflow) |-> (result == FULL));
   // R5: a tripped result stays below full scale
   a_r5_trip_range: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !overflow) |-> (result < FULL));
   // R9: outputs held between strobes
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> (valid || $stable(result)));
   // R2: integration follows start from idle
   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> en_input);
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           zero_cmp,
   output logic           en_input,
   output logic           en_ref,
   output logic [CNT_W:0] result,
   output logic           overflow,
   output logic           valid,
   output logic           busy
);
   if (CNT_W < 2 || CNT_W > 20) begin : g_bad_cnt_w
      $error("dual_slope_seq: CNT_W must lie in 2..20");
   end
   if (SYNC_STAGES != 2) begin : g_bad_sync
      $error("dual_slope_seq: comparator synchroniser depth must be 2");
   end

   logic             zero_s;
   logic             cnt_clr, cnt_inc;
   logic [CNT_W-1:0] cnt;

   dss_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(zero_cmp), .q(zero_s)
   );

   dss_counter #(.W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
   );

   dss_ctrl #(.CNT_W(CNT_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .zero_s(zero_s), .cnt(cnt),
      .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .en_input(en_input),
      .en_ref(en_ref), .busy(busy), .valid(valid), .result(result),
      .overflow(overflow)
   );
endmodule

// File: tb/test_dual_slope_seq.sv
module test_dual_slope_seq;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 10;
   localparam int WIN        = 1 << CNT_W;
   localparam int WATCHDOG   = 150000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           zero_cmp = 1'b0;
   logic           en_input, en_ref, overflow, valid, busy;
   logic [CNT_W:0] result;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_slope_seq #(.CNT_W(CNT_W)) i_dual_slope_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .zero_cmp(zero_cmp),
      .en_input(en_input), .en_ref(en_ref), .result(result),
      .overflow(overflow), .valid(valid), .busy(busy)
   );

   function automatic int exp_result(int j);
      if (j < 0)             return 0;
      else if (j + 2 <= WIN - 1) return j + 2;
      else                   return WIN;
   endfunction

   function automatic int exp_ref_cycles(int j);
      int r = exp_result(j);
      return (r == WIN) ? WIN : r + 1;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // j: discharge cycle in which the comparator rises (<0: high from before)
   // poke: discharge cycle in which a stray start arrives (<0: none)
   task automatic run_conv(input int j, input int poke);
      logic [CNT_W:0] prev_res = result;
      logic           prev_ovf = overflow;
      int n, k;
      zero_cmp = (j < 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 en_input after start", en_input, 1);
      chk("R2 busy after start", busy, 1);
      chk("R9 result held", result, prev_res);
      chk("R9 overflow held", overflow, prev_ovf);
      n = 0;
      while (en_input && n <= WIN + 4) begin
         n++;
         @(negedge clk);
      end
      chk("R3 integration length", n, WIN);
      chk("R4 gap cycle both low", {en_input, en_ref}, 0);
      @(negedge clk);
      chk("R4 reference after gap", en_ref, 1);
      k = 0;
      while (en_ref && k <= WIN + 4) begin
         if (k == j) zero_cmp = 1'b1;
         start = (k == poke);
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      chk("R7 valid after discharge", valid, 1);
      chk("R7 idle at valid", {busy, en_input, en_ref}, 0);
      if (j < 0) begin
         chk("R10 result comparator pre-tripped", result, 0);
         chk("R10 reference cycles", k, 1);
      end else if (exp_result(j) == WIN) begin
         chk("R6 saturated result", result, WIN);
         chk("R6 overflow flag", overflow, 1);
         chk("R6 reference cycles", k, WIN);
      end else begin
         chk("R5 result", result, exp_result(j));
         chk("R5 reference cycles", k, exp_ref_cycles(j));
         chk("R9 overflow cleared on trip", overflow, 0);
      end
      zero_cmp = 1'b0;
      @(negedge clk);
      chk("R7 valid single cycle", valid, 0);
      if (poke >= 0) begin
         repeat (3) @(negedge clk);
         chk("R8 start while busy ignored", {en_input, busy}, 0);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      summary();
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      chk("R1 outputs in reset", {en_input, en_ref, busy, valid, overflow}, 0);
      chk("R1 result in reset", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs after reset", {en_input, en_ref, busy, valid, overflow}, 0);
      chk("R1 result after reset", result, 0);

      // directed corner cases
      run_conv(0, -1);
      run_conv(-1, -1);          // R10
      run_conv(WIN - 3, -1);     // largest tripped value
      run_conv(WIN - 2, -1);     // R6 first overflow case
      run_conv(WIN + 20, -1);    // R6 comparator never trips
      run_conv(10, -1);          // R9 overflow clears
      run_conv(500, 5);          // R8 stray start
      run_conv(-1, 0);           // R8 stray start on the only cycle

      // constrained random trips
      for (int t = 0; t < 24; t++) begin
         int r = int'($urandom % (WIN + 8));
         int j = (r % 11 == 0) ? -1 : r;
         int p = (t % 4 == 0) ? 1 : -1;
         run_conv(j, p);
         repeat (int'($urandom % 4)) @(negedge clk);
      end

      summary();
      $finish;
   end
endmodule